// File: doc/BRIEF.md
# Serial avionics word transmitter channel

This block is one transmit channel that turns bytes from a host into a 32-bit serial avionics word. The host places a byte on a shared 8-bit bus and pulses an active-low load strobe. The channel captures the byte on the strobe's rising edge. Four strobes fill the word. The first byte supplies word bits 0 to 7, the second bits 8 to 15, and so on. The top bit of the fourth byte is dropped, and an odd-parity bit is sent in its place as the 32nd bit.

The word goes out least significant bit first, as return-to-zero pulses on two lines. A pulse on one line means a one and a pulse on the other line means a zero. A speed input selects the bit period: the system clock divided by one of two parameterised ratios. The default ratios are 50 and 380. The completion output is high while the channel is ready for bytes. It goes low once the word is full and rises again when the last bit has gone out.

An arm latch, set by the active-low transmit-enable input, decides when sending begins. A short low pulse on that input gives controlled start. Holding it low gives auto-start as soon as the fourth byte arrives.

Top module: `arinc_word_tx`

## Requirements
- R1: Bytes are captured on rising edges of `load_n` while `tx_complete` is high. Byte k (k = 0..3, in load order) becomes word bits 8k to 8k+7. Word bit i is the i-th bit transmitted, so bit 0 of the first byte goes first.
- R2: On the clock edge that captures the fourth byte, `tx_complete` goes low. Load strobes seen while it is low change neither the stored word nor the byte position.
- R3: Transmitted bit 31 is odd parity over bits 0..30: 1 when those bits hold an even number of ones, 0 otherwise. Bit 7 of the fourth byte never reaches the lines.
- R4: Each bit lasts FAST_DIV clock cycles when `fast_sel` is 1 and SLOW_DIV cycles when it is 0. The value is taken when the word starts, so a change during a word has no effect on that word.
- R5: A one is sent as `pulse_one` high and a zero as `pulse_zero` high, during the first half (DIV/2 cycles) of its bit. Both lines are low for the rest of each bit, while `tx_complete` is high, and never high together.
- R6: Every clock cycle in which `txen_n` is sampled low sets the arm latch. Sending starts on the first clock edge at which the latch is set and `tx_complete` is low, and starting clears the latch. A latch set before or during loading therefore starts the next word at once.
- R7: With `txen_n` held low, the first pulse begins on the clock edge after the one on which `tx_complete` falls.
- R8: With the latch clear, a full word waits with both lines low and `tx_complete` low for as long as `txen_n` stays high.
- R9: `tx_complete` rises on the clock edge that ends the 32nd bit period, after exactly 32 pulses, and the channel then accepts a new word.
- R10: While `rst` is high, every clock edge forces `tx_complete` high, both lines low, the byte position to the first byte and the arm latch clear, including in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock the bit rate is divided from |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | Byte presented by the host |
| load_n | input | 1 | Active-low load strobe; its rising edge captures `bus_data` |
| txen_n | input | 1 | Active-low transmit enable; sets the arm latch |
| fast_sel | input | 1 | 1 selects the FAST_DIV bit period, 0 the SLOW_DIV bit period |
| pulse_one | output | 1 | Return-to-zero pulse line for one bits |
| pulse_zero | output | 1 | Return-to-zero pulse line for zero bits |
| tx_complete | output | 1 | High while the channel accepts bytes; low while a word waits or is sent |

## Verification
The bench builds the channel with FAST_DIV = 4 and SLOW_DIV = 6, so a word lasts about 130 to 200 cycles instead of several thousand. This makes it cheap to send dozens of complete words at both rates. Those words include all-zeros, all-ones, a walking one and a walking zero across all 31 data bits, each with the dropped top bit set to the wrong parity value. Every cycle of every bit is compared against the pulse shape worked out arithmetically. The short words also leave room to test strobes during waiting and sending, a speed change in mid-word, arming before loading, and resets both during a partial load and in the middle of a word.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;

    typedef enum logic [1:0] {
        PH_FILL  = 2'd0,
        PH_HOLD  = 2'd1,
        PH_SHIFT = 2'd2
    } tx_phase_e;

    typedef struct packed {
        logic one;
        logic zero;
    } rz_pair_t;

    function automatic rz_pair_t rz_encode(input logic bit_v, input logic active);
        rz_pair_t p;
        p.one  = active & bit_v;
        p.zero = active & ~bit_v;
        return p;
    endfunction

endpackage

// File: rtl/arinc_tx_loader.sv
module arinc_tx_loader #(
    parameter int BYTE_W   = 8,
    parameter int BYTE_CNT = 4,
    localparam int WORD_W  = BYTE_W * BYTE_CNT,
    localparam int CNT_W   = $clog2(BYTE_CNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] bus_data,
    input  logic              load_n,
    input  logic              accept,
    output logic [WORD_W-2:0] word_o,
    output logic              full_o
);

    logic             load_q;
    logic [CNT_W-1:0] byte_idx;
    logic             grab;
    logic             last_byte;

    assign grab      = accept & load_n & ~load_q;
    assign last_byte = (byte_idx == CNT_W'(BYTE_CNT - 1));
    assign full_o    = grab & last_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q   <= 1'b1;
            byte_idx <= '0;
        end else begin
            load_q <= load_n;
            if (grab) begin
                byte_idx <= last_byte ? '0 : byte_idx + 1'b1;
            end
        end
    end

    for (genvar k = 0; k < BYTE_CNT; k++) begin : g_slot
        if (k == BYTE_CNT - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_o[k*BYTE_W +: BYTE_W-1] <= '0;
                end else if (grab && byte_idx == CNT_W'(k)) begin
                    word_o[k*BYTE_W +: BYTE_W-1] <= bus_data[BYTE_W-2:0];
                end
            end
        end else begin : g_full
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_o[k*BYTE_W +: BYTE_W] <= '0;
                end else if (grab && byte_idx == CNT_W'(k)) begin
                    word_o[k*BYTE_W +: BYTE_W] <= bus_data;
                end
            end
        end
    end

endmodule

// File: rtl/arinc_tx_bitclk.sv
module arinc_tx_bitclk #(
    parameter int FAST_DIV = 50,
    parameter int SLOW_DIV = 380,
    localparam int CNT_W   = $clog2(SLOW_DIV)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic bit_end,
    output logic first_half
);

    localparam logic [CNT_W-1:0] LIM_FAST  = CNT_W'(FAST_DIV - 1);
    localparam logic [CNT_W-1:0] LIM_SLOW  = CNT_W'(SLOW_DIV - 1);
    localparam logic [CNT_W-1:0] HALF_FAST = CNT_W'(FAST_DIV / 2);
    localparam logic [CNT_W-1:0] HALF_SLOW = CNT_W'(SLOW_DIV / 2);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] half;

    assign lim        = fast ? LIM_FAST : LIM_SLOW;
    assign half       = fast ? HALF_FAST : HALF_SLOW;
    assign bit_end    = run & (cnt == lim);
    assign first_half = run & (cnt < half);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/arinc_tx_sequencer.sv
module arinc_tx_sequencer
    import arinc_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_full,
    input  logic [WORD_W-2:0] word_in,
    input  logic              txen_n,
    input  logic              fast_sel,
    input  logic              bit_end,
    input  logic              first_half,
    output logic              accept,
    output logic              run,
    output logic              fast_q,
    output rz_pair_t          line
);

    tx_phase_e        phase;
    logic             armed;
    logic             start;
    logic [WORD_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;

    assign start  = (phase == PH_HOLD) & armed;
    assign accept = (phase == PH_FILL);
    assign run    = (phase == PH_SHIFT);
    assign line   = rz_encode(shreg[0], run & first_half);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_FILL;
            armed   <= 1'b0;
            shreg   <= '0;
            bit_idx <= '0;
            fast_q  <= 1'b0;
        end else begin
            armed <= ~txen_n | (armed & ~start);
            case (phase)
                PH_FILL: begin
                    if (word_full) phase <= PH_HOLD;
                end
                PH_HOLD: begin
                    if (armed) begin
                        phase   <= PH_SHIFT;
                        shreg   <= {~^word_in, word_in};
                        bit_idx <= '0;
                        fast_q  <= fast_sel;
                    end
                end
                PH_SHIFT: begin
                    if (bit_end) begin
                        shreg <= shreg >> 1;
                        if (bit_idx == IDX_W'(WORD_W - 1)) begin
                            phase <= PH_FILL;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                default: phase <= PH_FILL;
            endcase
        end
    end

endmodule

// File: rtl/arinc_word_tx.sv
module arinc_word_tx
    import arinc_tx_pkg::*;
#(
    parameter int FAST_DIV = 50,
    parameter int SLOW_DIV = 380,
    parameter int BYTE_W   = 8,
    parameter int BYTE_CNT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] bus_data,
    input  logic              load_n,
    input  logic              txen_n,
    input  logic              fast_sel,
    output logic              pulse_one,
    output logic              pulse_zero,
    output logic              tx_complete
);

    localparam int WORD_W = BYTE_W * BYTE_CNT;

    logic [WORD_W-2:0] word;
    logic              word_full;
    logic              accept;
    logic              run;
    logic              fast_q;
    logic              bit_end;
    logic              first_half;
    rz_pair_t          line;

    arinc_tx_loader #(
        .BYTE_W  (BYTE_W),
        .BYTE_CNT(BYTE_CNT)
    ) u_loader (
        .clk     (clk),
        .rst     (rst),
        .bus_data(bus_data),
        .load_n  (load_n),
        .accept  (accept),
        .word_o  (word),
        .full_o  (word_full)
    );

    arinc_tx_bitclk #(
        .FAST_DIV(FAST_DIV),
        .SLOW_DIV(SLOW_DIV)
    ) u_bitclk (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .fast      (fast_q),
        .bit_end   (bit_end),
        .first_half(first_half)
    );

    arinc_tx_sequencer #(
        .WORD_W(WORD_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .word_full (word_full),
        .word_in   (word),
        .txen_n    (txen_n),
        .fast_sel  (fast_sel),
        .bit_end   (bit_end),
        .first_half(first_half),
        .accept    (accept),
        .run       (run),
        .fast_q    (fast_q),
        .line      (line)
    );

    assign pulse_one   = line.one;
    assign pulse_zero  = line.zero;
    assign tx_complete = accept;

endmodule

// File: rtl/arinc_word_tx_chk.sv
module arinc_word_tx_chk #(
    parameter int SLOW_DIV = 380,
    parameter int WORD_W   = 32
) (
    input logic clk,
    input logic rst,
    input logic pulse_one,
    input logic pulse_zero,
    input logic tx_complete
);

    localparam int HR_W = $clog2(SLOW_DIV) + 1;
    localparam int PC_W = $clog2(WORD_W + 1) + 1;

    logic            rst_q;
    logic            line_q;
    logic [HR_W-1:0] high_run;
    logic [PC_W-1:0] pulses;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q   <= 1'b0;
            high_run <= '0;
            pulses   <= '0;
        end else begin
            line_q   <= pulse_one | pulse_zero;
            high_run <= (pulse_one | pulse_zero) ? high_run + 1'b1 : '0;
            if (tx_complete) begin
                pulses <= '0;
            end else if ((pulse_one | pulse_zero) && !line_q) begin
                pulses <= pulses + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_state_R10: assert (tx_complete && !pulse_one && !pulse_zero);
        end
        rst_q <= rst;
    end

    assert_split_lines_R5: assert property (@(posedge clk) disable iff (rst)
        !(pulse_one && pulse_zero));

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        tx_complete |-> (!pulse_one && !pulse_zero));

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
        high_run <= HR_W'(SLOW_DIV / 2));

    assert_word_length_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_complete) |-> (pulses == PC_W'(WORD_W)));

endmodule

bind arinc_word_tx arinc_word_tx_chk #(
    .SLOW_DIV(SLOW_DIV),
    .WORD_W  (WORD_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pulse_one  (pulse_one),
    .pulse_zero (pulse_zero),
    .tx_complete(tx_complete)
);

// File: tb/arinc_word_tx_tb.sv
module arinc_word_tx_tb;

    localparam int FD = 4;
    localparam int SD = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_data;
    logic       load_n;
    logic       txen_n;
    logic       fast_sel;
    logic       pulse_one;
    logic       pulse_zero;
    logic       tx_complete;

    int checks = 0;
    int errors = 0;
    int lat;
    int bad;
    bit done = 1'b0;

    always #10 clk = ~clk;

    arinc_word_tx #(
        .FAST_DIV(FD),
        .SLOW_DIV(SD)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_data   (bus_data),
        .load_n     (load_n),
        .txen_n     (txen_n),
        .fast_sel   (fast_sel),
        .pulse_one  (pulse_one),
        .pulse_zero (pulse_zero),
        .tx_complete(tx_complete)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] raw);
        logic [31:0] e;
        e     = raw;
        e[31] = ~^raw[30:0];
        return e;
    endfunction

    function automatic logic [31:0] gen(input int i);
        if (i == 0) return 32'h0;
        if (i == 1) return 32'hFFFF_FFFF;
        return (32'h9E37_79B9 * 32'(i + 3)) ^ (32'h0F0F_00FF << i);
    endfunction

    task automatic strobe(input logic [7:0] b);
        @(negedge clk);
        bus_data = b;
        load_n   = 1'b0;
        @(negedge clk);
        load_n   = 1'b1;
    endtask

    task automatic load_word(input logic [31:0] raw);
        for (int k = 0; k < 4; k++) begin
            strobe(raw[8*k +: 8]);
            if (k < 3) @(negedge clk);
        end
    endtask

    task automatic watch_word(input int div, input logic [31:0] exp, input string req,
                              output int latency);
        logic [31:0] rx = '0;
        int shape = 0;
        latency = 0;
        while (!(pulse_one || pulse_zero) && latency < 3000) begin
            @(negedge clk);
            latency++;
        end
        for (int b = 0; b < 32; b++) begin
            for (int c = 0; c < div; c++) begin
                logic hi;
                if (b != 0 || c != 0) @(negedge clk);
                if (c == 0) rx[b] = pulse_one;
                hi = (c < div / 2);
                if (pulse_one !== (hi & exp[b]) || pulse_zero !== (hi & ~exp[b])) shape++;
            end
        end
        check(rx == exp, {req, " R1 R3 word"}, rx, exp);
        check(shape == 0, {req, " R4 R5 pulse shape"}, shape, 0);
        @(negedge clk);
        check(tx_complete == 1'b1, {req, " R9 complete after last bit"}, tx_complete, 1);
    endtask

    task automatic idle_window(input int n, input string req);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pulse_one || pulse_zero || tx_complete) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        rst      = 1'b1;
        bus_data = 8'h00;
        load_n   = 1'b1;
        txen_n   = 1'b0;
        fast_sel = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_complete == 1'b1, "R10 reset complete high", tx_complete, 1);
        check({pulse_one, pulse_zero} == 2'b00, "R10 reset lines low", {pulse_one, pulse_zero}, 0);
        rst = 1'b0;

        // R7: auto-start sweep at both rates
        for (int sp = 0; sp < 2; sp++) begin
            fast_sel = (sp == 0);
            for (int i = 0; i < 12; i++) begin
                logic [31:0] raw = gen(i);
                load_word(raw);
                watch_word(fast_sel ? FD : SD, expect_word(raw), "sweep", lat);
                check(lat == 2, "R7 auto-start latency", lat, 2);
            end
        end

        // R3: walking one and walking zero, dropped bit set to the wrong parity
        fast_sel = 1'b1;
        for (int j = 0; j < 31; j++) begin
            logic [31:0] raw = 32'(1) << j;
            raw[31] = 1'b1;
            load_word(raw);
            watch_word(FD, expect_word(raw), "walk1 R3", lat);
            raw = ~(32'(1) << j);
            raw[31] = 1'b0;
            load_word(raw);
            watch_word(FD, expect_word(raw), "walk0 R3", lat);
        end

        // R4: speed change in mid-word is ignored
        load_word(32'hC3A5_5A3C);
        fork
            watch_word(FD, expect_word(32'hC3A5_5A3C), "R4 speed held", lat);
            begin
                repeat (20) @(negedge clk);
                fast_sel = 1'b0;
            end
        join
        fast_sel = 1'b1;

        // R2: strobes during sending are ignored
        load_word(32'h1357_9BDF);
        fork
            watch_word(FD, expect_word(32'h1357_9BDF), "R2 send", lat);
            begin
                repeat (30) @(negedge clk);
                for (int k = 0; k < 3; k++) begin
                    strobe(8'hA5);
                    @(negedge clk);
                end
            end
        join
        load_word(32'h2468_ACE0);
        watch_word(FD, expect_word(32'h2468_ACE0), "R2 after ignored strobes", lat);

        // R10: reset during a partial load clears byte position and latch
        txen_n = 1'b1;
        @(negedge clk);
        strobe(8'h11);
        @(negedge clk);
        strobe(8'h22);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_complete == 1'b1, "R10 reset after partial load", tx_complete, 1);
        rst = 1'b0;

        // R8: word waits with latch clear; R2: strobes while waiting ignored
        load_word(32'h8BAD_F00D);
        idle_window(20, "R8 waiting word stays quiet");
        strobe(8'h77);
        @(negedge clk);
        strobe(8'h88);
        idle_window(20, "R8 R2 quiet after strobes while waiting");

        // R6: controlled start by a single enable pulse
        @(negedge clk);
        txen_n = 1'b0;
        fork
            watch_word(FD, expect_word(32'h8BAD_F00D), "R6 controlled", lat);
            begin
                @(negedge clk);
                txen_n = 1'b1;
            end
        join
        check(lat == 2, "R6 start latency after enable", lat, 2);

        // R6: latch was cleared by the start, next word waits
        load_word(32'h0F1E_2D3C);
        idle_window(30, "R6 latch cleared at start");
        @(negedge clk);
        txen_n = 1'b0;
        @(negedge clk);
        txen_n = 1'b1;
        watch_word(FD, expect_word(32'h0F1E_2D3C), "R6 second controlled", lat);

        // R6: enable pulse before loading arms the next word
        @(negedge clk);
        txen_n = 1'b0;
        @(negedge clk);
        txen_n = 1'b1;
        load_word(32'h7E57_C0DE);
        watch_word(FD, expect_word(32'h7E57_C0DE), "R6 armed early", lat);
        check(lat == 2, "R6 armed early latency", lat, 2);

        // R10: reset in the middle of a word
        txen_n = 1'b0;
        load_word(32'hDEAD_BEEF);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(tx_complete == 1'b1, "R10 mid-word reset complete", tx_complete, 1);
        check({pulse_one, pulse_zero} == 2'b00, "R10 mid-word reset lines", {pulse_one, pulse_zero}, 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        load_word(32'h5A5A_0FF0);
        watch_word(FD, expect_word(32'h5A5A_0FF0), "R10 restart", lat);
        check(lat == 2, "R7 latency after reset", lat, 2);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule